// File: doc/BRIEF.md
# Clear-Only Flash Read-Protection Bank

This block keeps the read permissions for a 1MB flash array. The array is split into 2KB blocks and each block has one enable bit. The bits sit in sixteen 32-bit working registers, so each register covers one 64KB region. Software reaches the registers over a plain register bus with an address, write data, a write strobe and combinational read data.

A register write can only lower bits. A lowered bit is temporary until software issues a commit strobe together with the correct 16-bit key. The commit copies every working register into a persistent image, which models the nonvolatile cells. A power-on reset reloads the working registers from that image, so uncommitted clears are undone. A warm reset leaves the bits alone. A recover input is the only way to bring both the image and the working registers back to the factory state of all ones.

On the flash data path, each read address selects a register and a bit. If that bit is 0, the block returns zero data and flags an access error. If the bit is 1, the flash data passes through unchanged.

Top module: `flash_rdprot_bank`

## Requirements
- R1: After recover followed by a power-on reset, every register reads 0xFFFFFFFF and every flash read passes with rd_err = 0.
- R2: Register n (n = 0..15) is at byte offset 0x200 + 4*n with reg_addr[1:0] = 0, and reading it returns its working value.
- R3: A write to a register stores old AND reg_wdata. Writing a 1 never raises a bit that is already 0.
- R4: A warm reset (warm_n low) leaves every working register unchanged and clears busy.
- R5: A power-on reset (por_n low) reloads every working register from the committed image. An uncommitted clear therefore returns to 1 when its committed bit is 1.
- R6: commit_req with commit_key = 0xC3A5 while busy = 0 copies all working registers into the image, and a committed 0 survives power-on reset. A commit with any other key changes neither the image nor busy.
- R7: After an accepted commit, busy reads 1 for exactly BUSY_CYCLES clock cycles. Register writes and further commits are ignored while busy = 1.
- R8: A flash read at rd_addr uses register rd_addr[19:16] and bit rd_addr[15:11]. If that bit is 0 and rd_valid = 1, then rd_err = 1 and rd_data = 0. Otherwise rd_data = flash_rdata, and rd_err = 0 whenever rd_valid = 0.
- R9: Offsets below 0x200, offsets above 0x23C and offsets that are not word aligned read as zero, and writes to them change no register.
- R10: While recover = 1 at a clock edge, both the image and the working registers are set to all ones. Recover takes priority over commit, power-on reload and writes.
- R11: Clearing eight consecutive bits 8k..8k+7 of one register blocks the whole aligned 16KB sector k of that 64KB region, while the blocks just below and just above the sector stay readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous active low |
| warm_n | input | 1 | Warm reset, asynchronous active low |
| recover | input | 1 | Restores factory state (all ones) |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data (clear mask where 0) |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 32 | Register read data (working value) |
| commit_req | input | 1 | Commit strobe |
| commit_key | input | 16 | Commit key, must equal 0xC3A5 |
| busy | output | 1 | Commit in progress |
| rd_valid | input | 1 | Flash data read valid |
| rd_addr | input | 20 | Flash byte address of the read |
| flash_rdata | input | 32 | Data from the flash array |
| rd_data | output | 32 | Data returned to the requester |
| rd_err | output | 1 | Read blocked by protection |

## Verification
The bench builds the block with the default geometry: sixteen 32-bit registers, 2KB blocks and a 20-bit flash address. This puts the last register, bit 31 and sector boundaries inside a 64KB region within reach. BUSY_CYCLES is lowered to 4, so the bench can count the whole busy window and then check that writes take effect again. Power-on and warm resets are applied in the middle of the run, with committed and uncommitted clears present, so the reload and hold behaviour is observed at the register bus.

// File: rtl/frp_pkg.sv
package frp_pkg;
  localparam int unsigned FRP_NUM_REGS    = 16;
  localparam int unsigned FRP_REG_W       = 32;
  localparam int unsigned FRP_BLOCK_SHIFT = 11;
  localparam int unsigned FRP_KEY_W       = 16;
  localparam logic [FRP_KEY_W-1:0] FRP_COMMIT_KEY = 16'hC3A5;

  // source selected for a working register's next value
  typedef enum logic [1:0] {
    WSRC_HOLD,
    WSRC_CLEAR,
    WSRC_IMAGE,
    WSRC_ONES
  } wsrc_e;
endpackage

// File: rtl/frp_rst_sync.sv
module frp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/frp_regfile.sv
module frp_regfile
  import frp_pkg::*;
#(
  parameter int unsigned NUM_REGS = FRP_NUM_REGS,
  parameter int unsigned REG_W    = FRP_REG_W,
  parameter int unsigned IDX_W    = $clog2(FRP_NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           recover,
  input  logic                           load_image,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [REG_W-1:0]               wr_data,
  input  logic                           commit_go,
  output logic [NUM_REGS-1:0][REG_W-1:0] work_o,
  output logic [NUM_REGS-1:0][REG_W-1:0] image_o
);
  // persistent image: no reset, only recover or commit may change it
  logic                           img_en;
  logic [NUM_REGS-1:0][REG_W-1:0] img_d;
  logic [NUM_REGS-1:0][REG_W-1:0] image_q;

  always_comb begin
    img_en = recover | commit_go;
    img_d  = recover ? {NUM_REGS{ {REG_W{1'b1}} }} : work_o;
  end

  always_ff @(posedge clk) begin
    if (img_en) image_q <= img_d;
  end

  assign image_o = image_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    wsrc_e           sel;
    logic            en;
    logic [REG_W-1:0] d;
    logic [REG_W-1:0] q;

    always_comb begin
      if (recover)                               sel = WSRC_ONES;
      else if (load_image)                       sel = WSRC_IMAGE;
      else if (wr_en && wr_idx == IDX_W'(i))     sel = WSRC_CLEAR;
      else                                       sel = WSRC_HOLD;
    end

    always_comb begin
      case (sel)
        WSRC_ONES:  d = '1;
        WSRC_IMAGE: d = image_q[i];
        WSRC_CLEAR: d = q & wr_data;
        default:    d = q;
      endcase
      en = (sel != WSRC_HOLD);
    end

    always_ff @(posedge clk) begin
      if (en) q <= d;
    end

    assign work_o[i] = q;
  end
endmodule

// File: rtl/frp_commit_ctrl.sv
module frp_commit_ctrl #(
  parameter int unsigned       BUSY_CYCLES = 8,
  parameter int unsigned       KEY_W       = 16,
  parameter logic [KEY_W-1:0]  KEY         = 16'hC3A5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit_req,
  input  logic [KEY_W-1:0] commit_key,
  output logic             commit_go,
  output logic             busy
);
  localparam int unsigned CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    busy      = (cnt_q != '0);
    commit_go = rst_n & commit_req & (commit_key == KEY) & ~busy;
    cnt_en    = commit_go | busy;
    cnt_d     = commit_go ? CNT_W'(BUSY_CYCLES) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/frp_read_guard.sv
module frp_read_guard #(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned BLOCK_SHIFT = 11,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned FLASH_AW    = 20
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] work,
  input  logic                           rd_valid,
  input  logic [FLASH_AW-1:0]            rd_addr,
  input  logic [DATA_W-1:0]              flash_rdata,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_err
);
  localparam int unsigned BIT_W = $clog2(REG_W);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);

  logic [BIT_W-1:0] bit_sel;
  logic [IDX_W-1:0] reg_sel;
  logic             permit;

  always_comb begin
    bit_sel = rd_addr[BLOCK_SHIFT +: BIT_W];
    reg_sel = rd_addr[BLOCK_SHIFT + BIT_W +: IDX_W];
    permit  = work[reg_sel][bit_sel];
    rd_err  = rd_valid & ~permit;
    rd_data = permit ? flash_rdata : '0;
  end
endmodule

// File: rtl/flash_rdprot_bank.sv
module flash_rdprot_bank
  import frp_pkg::*;
#(
  parameter int unsigned          NUM_REGS    = FRP_NUM_REGS,
  parameter int unsigned          REG_W       = FRP_REG_W,
  parameter int unsigned          BLOCK_SHIFT = FRP_BLOCK_SHIFT,
  parameter int unsigned          DATA_W      = 32,
  parameter int unsigned          REG_AW      = 12,
  parameter logic [11:0]          REG_BASE    = 12'h200,
  parameter int unsigned          KEY_W       = FRP_KEY_W,
  parameter logic [KEY_W-1:0]     COMMIT_KEY  = FRP_COMMIT_KEY,
  parameter int unsigned          BUSY_CYCLES = 8,
  parameter int unsigned          FLASH_AW    = BLOCK_SHIFT + $clog2(REG_W) + $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              warm_n,
  input  logic              recover,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_we,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              commit_req,
  input  logic [KEY_W-1:0]  commit_key,
  output logic              busy,
  input  logic              rd_valid,
  input  logic [FLASH_AW-1:0] rd_addr,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_err
);
  localparam int unsigned IDX_W = $clog2(NUM_REGS);
  localparam logic [REG_AW-1:0] BASE_A = REG_AW'(REG_BASE);
  localparam logic [REG_AW-1:0] SPAN_A = REG_AW'(NUM_REGS * 4);

  logic por_rst_n, warm_rst_n, ctl_rst_n;
  logic commit_go;
  logic hit, wr_en;
  logic [REG_AW-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic [NUM_REGS-1:0][REG_W-1:0] work_q;
  logic [NUM_REGS-1:0][REG_W-1:0] image_q;

  frp_rst_sync #(.STAGES(2)) u_por_sync  (.clk(clk), .arst_n(por_n),  .srst_n(por_rst_n));
  frp_rst_sync #(.STAGES(2)) u_warm_sync (.clk(clk), .arst_n(warm_n), .srst_n(warm_rst_n));

  assign ctl_rst_n = por_rst_n & warm_rst_n;

  // register bus decode
  always_comb begin
    off   = reg_addr - BASE_A;
    idx   = off[IDX_W+1:2];
    hit   = (reg_addr[1:0] == 2'b00) && (reg_addr >= BASE_A) && (off < SPAN_A);
    wr_en = hit & reg_we & ~busy;
    reg_rdata = hit ? work_q[idx] : '0;
  end

  frp_commit_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES), .KEY_W(KEY_W), .KEY(COMMIT_KEY)
  ) u_ctrl (
    .clk(clk), .rst_n(ctl_rst_n), .commit_req(commit_req), .commit_key(commit_key),
    .commit_go(commit_go), .busy(busy)
  );

  frp_regfile #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .recover(recover), .load_image(~por_rst_n), .wr_en(wr_en),
    .wr_idx(idx), .wr_data(reg_wdata), .commit_go(commit_go),
    .work_o(work_q), .image_o(image_q)
  );

  frp_read_guard #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .BLOCK_SHIFT(BLOCK_SHIFT),
    .DATA_W(DATA_W), .FLASH_AW(FLASH_AW)
  ) u_guard (
    .work(work_q), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .flash_rdata(flash_rdata), .rd_data(rd_data), .rd_err(rd_err)
  );
endmodule

// File: rtl/frp_checker.sv
module frp_checker #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned REG_AW   = 12,
  parameter logic [11:0] REG_BASE = 12'h200
) (
  input logic                           clk,
  input logic                           por_rst_n,
  input logic                           recover,
  input logic [REG_AW-1:0]              reg_addr,
  input logic                           reg_we,
  input logic [REG_W-1:0]               reg_rdata,
  input logic                           busy,
  input logic                           commit_go,
  input logic [NUM_REGS-1:0][REG_W-1:0] work_q,
  input logic [NUM_REGS-1:0][REG_W-1:0] image_q,
  input logic                           rd_valid,
  input logic                           rd_err,
  input logic [DATA_W-1:0]              rd_data
);
  logic oob;
  assign oob = (reg_addr[1:0] != 2'b00) || (reg_addr < REG_AW'(REG_BASE)) ||
               (reg_addr >= REG_AW'(REG_BASE) + REG_AW'(NUM_REGS * 4));

  // R3: without recover or reload, no working bit ever rises
  a_r3_clear_only: assert property (@(posedge clk) disable iff (!por_rst_n)
    !recover |=> ((work_q & ~$past(work_q)) == '0));

  // R6: an accepted commit captures the working values into the image
  a_r6_commit_copy: assert property (@(posedge clk) disable iff (!por_rst_n)
    (commit_go && !recover) |=> (image_q == $past(work_q)));

  // R7: writes during busy leave the registers untouched
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!por_rst_n)
    (busy && reg_we && !recover) |=> $stable(work_q));

  // R8: a blocked read returns zero data; no error without a read
  a_r8_err_zero: assert property (@(posedge clk) disable iff (!por_rst_n)
    (rd_valid && rd_err) |-> (rd_data == '0));
  a_r8_no_err_idle: assert property (@(posedge clk) disable iff (!por_rst_n)
    !rd_valid |-> !rd_err);

  // R9: out-of-range offsets read zero
  a_r9_oob_zero: assert property (@(posedge clk) disable iff (!por_rst_n)
    oob |-> (reg_rdata == '0));

  // R10: recover drives image and working registers to all ones
  a_r10_recover: assert property (@(posedge clk) disable iff (!por_rst_n)
    recover |=> ((&image_q) && (&work_q)));
endmodule

bind flash_rdprot_bank frp_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DATA_W(DATA_W),
  .REG_AW(REG_AW), .REG_BASE(REG_BASE)
) u_chk (
  .clk(clk), .por_rst_n(por_rst_n), .recover(recover), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_rdata(reg_rdata), .busy(busy), .commit_go(commit_go),
  .work_q(work_q), .image_q(image_q), .rd_valid(rd_valid), .rd_err(rd_err),
  .rd_data(rd_data)
);

// File: tb/tb_flash_rdprot_bank.sv
`timescale 1ns/1ps
module tb_flash_rdprot_bank;
  localparam int unsigned BUSY = 4;
  localparam logic [15:0] KEY  = 16'hC3A5;

  logic        clk = 1'b0;
  logic        por_n, warm_n, recover;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_we, commit_req, busy;
  logic [15:0] commit_key;
  logic        rd_valid, rd_err;
  logic [19:0] rd_addr;
  logic [31:0] flash_rdata, rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_rdprot_bank #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .recover(recover),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata),
    .commit_req(commit_req), .commit_key(commit_key), .busy(busy),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .flash_rdata(flash_rdata),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_read(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic flash_read(input logic [19:0] a, input logic v,
                            output logic [31:0] d, output logic e);
    @(negedge clk);
    rd_addr = a; rd_valid = v; flash_rdata = 32'hA5A50000 ^ {12'h0, a};
    #1 d = rd_data; e = rd_err;
    rd_valid = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_commit(input logic [15:0] k);
    @(negedge clk);
    commit_req = 1'b1; commit_key = k;
    @(negedge clk);
    commit_req = 1'b0;
  endtask

  // R1: factory state after recover and power-on reset
  task automatic t_reset();
    logic [31:0] v; logic e;
    reg_read(12'h200, v); check("R1 reg0", v, 32'hFFFFFFFF);
    reg_read(12'h23C, v); check("R1 reg15", v, 32'hFFFFFFFF);
    flash_read(20'h12345, 1'b1, v, e);
    check("R1 read data", v, 32'hA5A50000 ^ 32'h12345);
    check("R1 read err", {31'b0, e}, 32'd0);
    check("R1 busy", {31'b0, busy}, 32'd0);
  endtask

  // R2, R3: map and clear-only write
  task automatic t_write();
    logic [31:0] v;
    reg_write(12'h20C, 32'hFFFF00FF);
    reg_read(12'h20C, v); check("R3 clear", v, 32'hFFFF00FF);
    reg_write(12'h20C, 32'hFFFFFFFF);
    reg_read(12'h20C, v); check("R3 no set", v, 32'hFFFF00FF);
    reg_write(12'h20C, 32'h0F0FFFFF);
    reg_read(12'h20C, v); check("R3 and", v, 32'h0F0F00FF);
    reg_read(12'h208, v); check("R2 neighbour", v, 32'hFFFFFFFF);
    reg_write(12'h23C, 32'h7FFFFFFF);
    reg_read(12'h23C, v); check("R2 last reg", v, 32'h7FFFFFFF);
  endtask

  // R8: per-address permission
  task automatic t_guard();
    logic [31:0] d; logic e;
    flash_read(20'h34000, 1'b1, d, e);
    check("R8 blocked err", {31'b0, e}, 32'd1);
    check("R8 blocked data", d, 32'd0);
    flash_read(20'h30000, 1'b1, d, e);
    check("R8 open err", {31'b0, e}, 32'd0);
    check("R8 open data", d, 32'hA5A50000 ^ 32'h30000);
    flash_read(20'hFF800, 1'b1, d, e);
    check("R8 reg15 bit31", {31'b0, e}, 32'd1);
    flash_read(20'hFF800, 1'b0, d, e);
    check("R8 idle no err", {31'b0, e}, 32'd0);
  endtask

  // R11: bits 8..15 of reg3 protect 0x34000..0x37FFF
  task automatic t_sector();
    logic [31:0] d; logic e;
    flash_read(20'h37FFC, 1'b1, d, e); check("R11 sector top", {31'b0, e}, 32'd1);
    flash_read(20'h35A00, 1'b1, d, e); check("R11 sector mid", {31'b0, e}, 32'd1);
    flash_read(20'h33FFC, 1'b1, d, e); check("R11 below", {31'b0, e}, 32'd0);
    flash_read(20'h38000, 1'b1, d, e); check("R11 above", {31'b0, e}, 32'd0);
  endtask

  // R9: out-of-range and misaligned offsets
  task automatic t_oob();
    logic [31:0] v;
    reg_read(12'h1FC, v); check("R9 below", v, 32'd0);
    reg_read(12'h240, v); check("R9 above", v, 32'd0);
    reg_read(12'h201, v); check("R9 misaligned", v, 32'd0);
    reg_write(12'h240, 32'h0);
    reg_write(12'h1FC, 32'h0);
    reg_write(12'h202, 32'h0);
    reg_read(12'h200, v); check("R9 reg0 kept", v, 32'hFFFFFFFF);
    reg_read(12'h23C, v); check("R9 reg15 kept", v, 32'h7FFFFFFF);
  endtask

  // R4: warm reset keeps bits
  task automatic t_warm();
    logic [31:0] v;
    @(negedge clk); warm_n = 1'b0;
    repeat (3) @(negedge clk);
    warm_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(12'h20C, v); check("R4 reg3 kept", v, 32'h0F0F00FF);
    reg_read(12'h23C, v); check("R4 reg15 kept", v, 32'h7FFFFFFF);
  endtask

  // R5: power-on reset undoes uncommitted clears
  task automatic t_por_uncommitted();
    logic [31:0] v;
    do_por();
    reg_read(12'h20C, v); check("R5 reg3 restored", v, 32'hFFFFFFFF);
    reg_read(12'h23C, v); check("R5 reg15 restored", v, 32'hFFFFFFFF);
  endtask

  // R6, R7: keyed commit and busy window
  task automatic t_commit();
    logic [31:0] v; logic e; int n;
    reg_write(12'h214, 32'hFFFFFFF0);
    do_commit(16'h1234);
    check("R6 bad key busy", {31'b0, busy}, 32'd0);
    do_por();
    reg_read(12'h214, v); check("R6 bad key no copy", v, 32'hFFFFFFFF);
    reg_write(12'h214, 32'hFFFFFFF0);
    @(negedge clk);
    commit_req = 1'b1; commit_key = KEY;
    @(negedge clk);                       // after commit edge: negedge 1
    commit_req = 1'b0;
    check("R7 busy set", {31'b0, busy}, 32'd1);
    reg_addr = 12'h214; reg_wdata = 32'h0; reg_we = 1'b1;
    @(negedge clk);                       // negedge 2
    reg_we = 1'b0;
    #1 check("R7 write ignored", reg_rdata, 32'hFFFFFFF0);
    n = 2;
    while (busy && n < 50) begin
      @(negedge clk); n++;
    end
    check("R7 busy length", n, BUSY + 1);
    reg_write(12'h218, 32'hFFFF0000);
    reg_read(12'h218, v); check("R7 write after busy", v, 32'hFFFF0000);
    do_por();
    reg_read(12'h214, v); check("R6 committed kept", v, 32'hFFFFFFF0);
    reg_read(12'h218, v); check("R5 uncommitted lost", v, 32'hFFFFFFFF);
    flash_read(20'h50000, 1'b1, v, e); check("R6 committed blocks", {31'b0, e}, 32'd1);
  endtask

  // R10: recover restores factory state across power-on reset
  task automatic t_recover();
    logic [31:0] v;
    @(negedge clk); recover = 1'b1;
    @(negedge clk); recover = 1'b0;
    reg_read(12'h214, v); check("R10 working ones", v, 32'hFFFFFFFF);
    do_por();
    reg_read(12'h214, v); check("R10 image ones", v, 32'hFFFFFFFF);
  endtask

  initial begin
    por_n = 1'b0; warm_n = 1'b1; recover = 1'b1;
    reg_addr = '0; reg_wdata = '0; reg_we = 1'b0;
    commit_req = 1'b0; commit_key = '0;
    rd_valid = 1'b0; rd_addr = '0; flash_rdata = '0;
    repeat (3) @(negedge clk);
    recover = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_guard();
    t_sector();
    t_oob();
    t_warm();
    t_por_uncommitted();
    t_commit();
    t_recover();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule